// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a write-back data cache. Its main array is direct mapped and sits beside a small fully associative victim buffer. A line pushed out of the main array is not dropped. It moves into the victim buffer, which keeps it until the buffer slot is needed again. When an access misses the main array, every victim entry is compared against the full line address. A match swaps the wanted line back into its main-array slot, and no memory traffic results. Only an access that misses both structures is sent to lower-level memory.

On the CPU side there is a single request port that reads or writes one word. `hit_o` marks the cycle in which the request completes, and `stall_o` tells the CPU to keep the request steady. On the memory side, whole lines move through a request/acknowledge handshake. Modified lines reach memory only when they leave the victim buffer. Victim slots are reused in order of insertion.

Top module: `dm_victim_cache`

## Requirements
- R1: After the asynchronous reset, both the main array and the victim buffer are empty. With no request, `hit_o`, `stall_o` and `mem_req_o` are 0. The first access to any line causes a memory read.
- R2: A request whose line is in the main array completes in the cycle it is presented (`hit_o`=1, `stall_o`=0). A read returns the stored word, with word `w` of a line at bits `[w*DATA_W +: DATA_W]`. A write updates that word.
- R3: A line displaced from the main array, by a fill or by a swap, is kept in the victim buffer and can be returned without a memory access.
- R4: A victim entry matches only when its full line address (tag and index together) equals the requested line address. A line with the same tag but a different index is not a victim hit.
- R5: A victim hit issues no memory request. It stalls for exactly one cycle and completes in the following cycle.
- R6: A victim hit exchanges the two lines in one step. The main-array line it displaces takes over the victim entry that was just freed, so two lines that conflict can alternate without memory traffic.
- R7: On a miss in both structures, one memory read is issued (`mem_we_o`=0, `mem_addr_o` = the word address with the offset bits dropped). The returned line is installed, and the request completes in the cycle after `mem_ack_i`.
- R8: When a displaced line needs a victim slot, it goes into the slot that was filled longest ago. If that slot holds a modified line, the slot is first written to memory (`mem_we_o`=1, with its line address and data). A clean line in that slot is overwritten without a write.
- R9: `mem_addr_o` and `mem_we_o` stay unchanged from the start of a memory request until it is acknowledged.
- R10: Written data is kept when its line moves into the victim buffer and back. It is also the data written to memory when the line is finally evicted.

The CPU keeps `req_i`, `we_i`, `addr_i` and `wdata_i` stable while `stall_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write word |
| rdata_o | output | DATA_W | Read word, valid while `hit_o` is 1 |
| hit_o | output | 1 | Request completes this cycle |
| stall_o | output | 1 | Request pending; hold inputs |
| mem_req_o | output | 1 | Memory line request |
| mem_we_o | output | 1 | 1 = write back a line, 0 = read a line |
| mem_addr_o | output | ADDR_W-log2(WORDS) | Line address |
| mem_wdata_o | output | DATA_W*WORDS | Line written back |
| mem_rdata_i | input | DATA_W*WORDS | Line returned, valid with `mem_ack_i` |
| mem_ack_i | input | 1 | One-cycle completion of a memory request |

## Verification
A directed sequence drives two lines that share an index back and forth. It separates a true main hit (no stall) from a victim swap (exactly one stall, no memory traffic) and from a full miss (one read). A same-tag, different-index access shows that victim matching uses the full line address and not just the tag. A chain of conflicting fills then overflows the buffer. This shows whether the oldest slot is the one replaced, and whether a dirty slot is written back before the new line is read while a clean one is not. After that, a few hundred random reads and writes are confined to a handful of tags on two indices. They are checked against a bench model of the expected placement, which predicts the stall count, the memory reads and the exact write-back line and data. This catches wrong FIFO order, lost dirty bits and stale data after swaps.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } vc_state_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int SETS   = 8,
  parameter int WORDS  = 2,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFS_W = $clog2(WORDS),
  localparam int LINE_W = DATA_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] line_o,
  input  logic              lw_en_i,
  input  logic [LINE_W-1:0] lw_line_i,
  input  logic              lw_dirty_i,
  input  logic              ww_en_i,
  input  logic [OFS_W-1:0]  ww_ofs_i,
  input  logic [DATA_W-1:0] ww_data_i
);
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];
  logic [SETS-1:0]   vld_q;
  logic [SETS-1:0]   dirty_q;

  assign valid_o = vld_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign line_o  = data_q[idx_i];
  assign hit_o   = vld_q[idx_i] && (tag_q[idx_i] == tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else if (lw_en_i) begin
      vld_q[idx_i]   <= 1'b1;
      dirty_q[idx_i] <= lw_dirty_i;
    end else if (ww_en_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (lw_en_i) begin
      tag_q[idx_i]  <= tag_i;
      data_q[idx_i] <= lw_line_i;
    end else if (ww_en_i) begin
      data_q[idx_i][ww_ofs_i*DATA_W +: DATA_W] <= ww_data_i;
    end
  end

  AST_WORD_WRITE_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ww_en_i |-> hit_o) else $error("word write without main hit"); // R2
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ENTRIES = 4,
  parameter int LADDR_W = 11,
  parameter int LINE_W  = 64,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LADDR_W-1:0] lk_laddr_i,
  output logic               hit_o,
  output logic [PTR_W-1:0]   hit_idx_o,
  output logic [LINE_W-1:0]  hit_line_o,
  output logic               hit_dirty_o,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               old_valid_o,
  output logic               old_dirty_o,
  output logic [LADDR_W-1:0] old_laddr_o,
  output logic [LINE_W-1:0]  old_line_o,
  input  logic               wr_en_i,
  input  logic [PTR_W-1:0]   wr_idx_i,
  input  logic [LADDR_W-1:0] wr_laddr_i,
  input  logic [LINE_W-1:0]  wr_line_i,
  input  logic               wr_dirty_i,
  input  logic               adv_i
);
  logic [LADDR_W-1:0] laddr_q [ENTRIES];
  logic [LINE_W-1:0]  line_q  [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [ENTRIES-1:0] match;
  logic [PTR_W-1:0]   ptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (laddr_q[g] == lk_laddr_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx_o = PTR_W'(i);
    end
  end

  assign hit_o       = |match;
  assign hit_line_o  = line_q[hit_idx_o];
  assign hit_dirty_o = dirty_q[hit_idx_o];
  assign ptr_o       = ptr_q;
  assign old_valid_o = vld_q[ptr_q];
  assign old_dirty_o = dirty_q[ptr_q];
  assign old_laddr_o = laddr_q[ptr_q];
  assign old_line_o  = line_q[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (wr_en_i) begin
        vld_q[wr_idx_i]   <= 1'b1;
        dirty_q[wr_idx_i] <= wr_dirty_i;
      end
      if (adv_i) ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      laddr_q[wr_idx_i] <= wr_laddr_i;
      line_q[wr_idx_i]  <= wr_line_i;
    end
  end

  AST_VB_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)) else $error("line held twice in victim buffer"); // R4
  AST_VB_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(vld_q) >= $past($countones(vld_q))) else $error("victim entry lost"); // R3
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic main_hit_i,
  input  logic main_valid_i,
  input  logic vb_hit_i,
  input  logic old_valid_i,
  input  logic old_dirty_i,
  input  logic mem_ack_i,
  output logic hit_o,
  output logic stall_o,
  output logic swap_o,
  output logic install_o,
  output logic word_wr_o,
  output logic mem_req_o,
  output logic mem_we_o
);
  vc_state_e st_q, st_d;
  logic idle, dbl_miss;

  assign idle      = (st_q == ST_IDLE);
  assign hit_o     = req_i && idle && main_hit_i;
  assign stall_o   = req_i && !hit_o;
  assign swap_o    = req_i && idle && !main_hit_i && vb_hit_i;
  assign dbl_miss  = req_i && idle && !main_hit_i && !vb_hit_i;
  assign word_wr_o = hit_o && we_i;
  assign install_o = (st_q == ST_FILL) && mem_ack_i;
  assign mem_req_o = !idle;
  assign mem_we_o  = (st_q == ST_WB);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (dbl_miss)
                 st_d = (main_valid_i && old_valid_i && old_dirty_i) ? ST_WB : ST_FILL;
      ST_WB:   if (mem_ack_i) st_d = ST_FILL;
      ST_FILL: if (mem_ack_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WB) |-> (old_valid_i && old_dirty_i)) else $error("write-back of clean slot"); // R8
  AST_NO_MEM_ON_VHIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_o |=> !mem_req_o) else $error("memory used on victim hit"); // R5
endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache #(
  parameter int DATA_W     = 32,
  parameter int WORDS      = 2,
  parameter int SETS       = 8,
  parameter int VB_ENTRIES = 4,
  parameter int ADDR_W     = 12,
  localparam int OFS_W     = $clog2(WORDS),
  localparam int IDX_W     = $clog2(SETS),
  localparam int LADDR_W   = ADDR_W - OFS_W,
  localparam int TAG_W     = LADDR_W - IDX_W,
  localparam int LINE_W    = DATA_W * WORDS,
  localparam int VB_PTR_W  = (VB_ENTRIES > 1) ? $clog2(VB_ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               hit_o,
  output logic               stall_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [LADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0]  mem_wdata_o,
  input  logic [LINE_W-1:0]  mem_rdata_i,
  input  logic               mem_ack_i
);
  logic [OFS_W-1:0]   ofs;
  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic [LADDR_W-1:0] laddr;

  assign ofs   = addr_i[OFS_W-1:0];
  assign laddr = addr_i[ADDR_W-1:OFS_W];
  assign idx   = laddr[IDX_W-1:0];
  assign tag   = laddr[LADDR_W-1:IDX_W];

  logic              m_hit, m_valid, m_dirty;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_line;
  logic              v_hit, v_hit_dirty, v_old_valid, v_old_dirty;
  logic [VB_PTR_W-1:0] v_hit_idx, v_ptr;
  logic [LINE_W-1:0]   v_hit_line, v_old_line;
  logic [LADDR_W-1:0]  v_old_laddr;
  logic swap, install, word_wr;
  logic              lw_en, lw_dirty;
  logic [LINE_W-1:0] lw_line;
  logic              vw_en, v_adv;

  assign lw_en    = swap || install;
  assign lw_line  = swap ? v_hit_line : mem_rdata_i;
  assign lw_dirty = swap && v_hit_dirty;
  assign v_adv    = install && m_valid;
  assign vw_en    = swap || v_adv;

  vc_main_array #(
    .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .idx_i(idx), .tag_i(tag),
    .hit_o(m_hit), .valid_o(m_valid), .dirty_o(m_dirty),
    .tag_o(m_tag), .line_o(m_line),
    .lw_en_i(lw_en), .lw_line_i(lw_line), .lw_dirty_i(lw_dirty),
    .ww_en_i(word_wr), .ww_ofs_i(ofs), .ww_data_i(wdata_i)
  );

  vc_victim_buf #(
    .ENTRIES(VB_ENTRIES), .LADDR_W(LADDR_W), .LINE_W(LINE_W)
  ) u_vb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lk_laddr_i(laddr),
    .hit_o(v_hit), .hit_idx_o(v_hit_idx), .hit_line_o(v_hit_line), .hit_dirty_o(v_hit_dirty),
    .ptr_o(v_ptr),
    .old_valid_o(v_old_valid), .old_dirty_o(v_old_dirty),
    .old_laddr_o(v_old_laddr), .old_line_o(v_old_line),
    .wr_en_i(vw_en),
    .wr_idx_i(swap ? v_hit_idx : v_ptr),
    .wr_laddr_i({m_tag, idx}),
    .wr_line_i(m_line),
    .wr_dirty_i(m_dirty),
    .adv_i(v_adv)
  );

  vc_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_i), .we_i(we_i),
    .main_hit_i(m_hit), .main_valid_i(m_valid), .vb_hit_i(v_hit),
    .old_valid_i(v_old_valid), .old_dirty_i(v_old_dirty),
    .mem_ack_i(mem_ack_i),
    .hit_o(hit_o), .stall_o(stall_o),
    .swap_o(swap), .install_o(install), .word_wr_o(word_wr),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o)
  );

  assign rdata_o     = m_line[ofs*DATA_W +: DATA_W];
  assign mem_addr_o  = mem_we_o ? v_old_laddr : laddr;
  assign mem_wdata_o = v_old_line;

  AST_SWAP_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |=> m_hit) else $error("swapped line not in main array"); // R6
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    install |=> m_hit) else $error("filled line not in main array"); // R7
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)))
    else $error("memory request changed before ack"); // R9
endmodule

// File: tb/sim_dm_victim_cache.sv
`timescale 1ns/1ps
module sim_dm_victim_cache;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int LAW = 11;
  localparam int LW = 64;
  localparam int NS = 8;
  localparam int NV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           req = 1'b0, we = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic           hit, stall, mem_req, mem_we, mem_ack;
  logic [LAW-1:0] mem_addr;
  logic [LW-1:0]  mem_wdata, mem_rdata;

  dm_victim_cache u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .hit_o(hit), .stall_o(stall),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  function automatic logic [DW-1:0] pat(int w);
    return (32'(w) * 32'h0001_0003) ^ 32'h5A00_00C3;
  endfunction

  // lower memory: 2-cycle latency, one-cycle ack
  logic [LW-1:0]   mem_q [2048];
  logic [2047:0]   mem_wr;
  int              lat_q, n_rd, n_wr, hold_err;
  logic [LAW-1:0]  rd_addr, wb_addr, start_addr;
  logic [LW-1:0]   wb_data;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; lat_q <= 0; n_rd <= 0; n_wr <= 0; hold_err <= 0; mem_wr <= '0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_q == 0) start_addr <= mem_addr;
      if (lat_q == 2) begin
        if (mem_addr != start_addr) hold_err <= hold_err + 1;
        mem_ack <= 1'b1; lat_q <= 0;
        if (mem_we) begin
          mem_q[mem_addr] <= mem_wdata; mem_wr[mem_addr] <= 1'b1;
          n_wr <= n_wr + 1; wb_addr <= mem_addr; wb_data <= mem_wdata;
        end else begin
          mem_rdata <= mem_wr[mem_addr] ? mem_q[mem_addr]
                     : {pat(2*int'(mem_addr)+1), pat(2*int'(mem_addr))};
          n_rd <= n_rd + 1; rd_addr <= mem_addr;
        end
      end else lat_q <= lat_q + 1;
    end
  end

  int n_chk = 0, n_bad = 0, cyc_total = 0;
  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total == 150000) begin
      $display("FAIL watchdog: act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
      $finish;
    end
  end

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // reference model of placement
  logic [DW-1:0] gold [4096];
  int  mtag [NS];
  bit  mval [NS], mdty [NS];
  int  vl [NV];
  bit  vv [NV], vd [NV];
  int  vp = 0;
  int  last_cyc, last_rd, last_wr, total_wr = 0;

  task automatic acc(bit w, int a, logic [DW-1:0] d);
    int l, ix, tg, kind, ewb_l, r0, w0, c, j, tl;
    bit ewb, hd, td;
    logic [DW-1:0] rd;
    l = a >> 1; ix = l % NS; tg = l / NS; ewb = 0; ewb_l = 0; kind = 2;
    if (mval[ix] && mtag[ix] == tg) kind = 0;
    else begin
      j = -1;
      for (int k = 0; k < NV; k++) if (vv[k] && vl[k] == l) j = k;
      if (j >= 0) begin
        kind = 1;
        tl = mtag[ix] * NS + ix; td = mdty[ix];
        mtag[ix] = tg; mdty[ix] = vd[j];
        vl[j] = tl; vd[j] = td;
      end else begin
        if (mval[ix]) begin
          ewb = vv[vp] && vd[vp]; ewb_l = vl[vp];
          vl[vp] = mtag[ix] * NS + ix; vd[vp] = mdty[ix]; vv[vp] = 1;
          vp = (vp + 1) % NV;
        end
        mval[ix] = 1; mtag[ix] = tg; mdty[ix] = 0;
      end
    end
    if (w) mdty[ix] = 1;

    @(negedge clk);
    req = 1'b1; we = w; addr = AW'(a); wdata = d;
    r0 = n_rd; w0 = n_wr; c = 0;
    #1;
    while (stall) begin @(negedge clk); #1; c++; end
    rd = rdata; hd = hit;
    @(posedge clk); #1;
    req = 1'b0;
    last_cyc = c; last_rd = n_rd - r0; last_wr = n_wr - w0; total_wr += last_wr;
    chk(hd, "R2", "hit_o at completion", longint'(hd), 1);
    if (!w) chk(rd == gold[a], "R10", "read data", rd, gold[a]);
    case (kind)
      0: chk(c == 0 && last_rd == 0, "R2", "main hit stall/reads", c, 0);
      1: chk(c == 1 && last_rd == 0 && last_wr == 0, "R5", "victim hit stall", c, 1);
      default: begin
        chk(last_rd == 1 && rd_addr == LAW'(l), "R7", "fill read addr", rd_addr, l);
        chk(last_wr == (ewb ? 1 : 0), "R8", "write-back count", last_wr, ewb);
        if (ewb) begin
          chk(wb_addr == LAW'(ewb_l), "R8", "write-back addr", wb_addr, ewb_l);
          chk(wb_data == {gold[2*ewb_l+1], gold[2*ewb_l]}, "R10", "write-back data",
              wb_data, {gold[2*ewb_l+1], gold[2*ewb_l]});
        end
      end
    endcase
    if (w) gold[a] = d;
  endtask

  function automatic int wa(int t, int i, int o);
    return (t * NS + i) * 2 + o;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) gold[i] = pat(i);
    for (int i = 0; i < NS; i++) begin mval[i] = 0; mdty[i] = 0; mtag[i] = 0; end
    for (int i = 0; i < NV; i++) begin vv[i] = 0; vd[i] = 0; vl[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!hit && !stall && !mem_req, "R1", "idle after reset", {hit, stall, mem_req}, 0);

    acc(0, wa(0,0,0), '0);
    chk(last_rd == 1, "R1", "first access reads memory", last_rd, 1);
    acc(0, wa(0,0,0), '0);
    chk(last_cyc == 0, "R2", "repeat is main hit", last_cyc, 0);
    acc(1, wa(0,0,1), 32'hDEAD_0001);
    acc(0, wa(0,0,1), '0);
    acc(0, wa(1,0,0), '0);
    acc(0, wa(0,1,0), '0);
    chk(last_rd == 1, "R4", "same tag other index misses victim", last_rd, 1);
    acc(0, wa(0,0,1), '0);
    chk(last_cyc == 1 && last_rd == 0, "R3", "displaced line recovered", last_cyc, 1);
    acc(0, wa(1,0,1), '0);
    chk(last_cyc == 1 && last_rd == 0, "R6", "swapped-out line swaps back", last_cyc, 1);
    acc(0, wa(0,0,0), '0);
    chk(last_cyc == 1 && last_rd == 0, "R6", "alternate again", last_cyc, 1);
    for (int t = 2; t < 8; t++) acc(0, wa(t,0,0), '0);
    chk(total_wr >= 1, "R8", "dirty victim written back", total_wr, 1);

    for (int n = 0; n < 400; n++) begin
      int t, i, o;
      bit w;
      t = int'($urandom % 6); i = int'($urandom % 2); o = int'($urandom % 2);
      w = ($urandom % 3) == 0;
      acc(w, wa(t, i, o), $urandom);
    end
    chk(hold_err == 0, "R9", "memory addr held to ack", hold_err, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule